// File: doc/BRIEF.md
# UART Receive Deframer

This block pulls characters off an asynchronous serial line. It passes the line through a short synchronizer. It then waits for a falling edge and confirms the start bit at its midpoint. After that it samples each later bit at mid-bit, using a 16x oversampling enable that a separate baud generator supplies. It shares a small line-control word with the transmit side. A two-bit length code sets how many data bits are expected. A parity-enable bit, an even-select bit and a stick-parity bit decide whether a parity bit follows the data and which value it must hold.

When a frame finishes at the middle of its stop bit, the block drives a one-cycle valid strobe. Alongside the strobe it presents the character (first bit received in bit 0, unused upper bits zero) and three flags: parity error, framing error and break. A line held low for a whole frame is reported as one zero character with the break flag set. The receiver then stays quiet until the line goes high again. Only one stop bit is ever sampled, so a new start bit may follow the first stop bit directly.

Top module: `uart_rx_deframer`

## Requirements
- R1: After reset `rx_valid`, `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are all zero.
- R2: A low level that is high again when the start bit is re-sampled, 8 ticks after the falling edge was seen, produces no character.
- R3: `cfg_wlen` selects the data bit count: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Bits arrive least significant first, and the bits of `rx_data` above the selected width read as zero.
- R4: With `cfg_par_en`=1 and `cfg_stick`=0, a parity bit follows the data. It must make the count of ones (data plus parity) odd when `cfg_even`=0 and even when `cfg_even`=1. A mismatch sets `rx_perr`.
- R5: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit must be 1 when `cfg_even`=0 and 0 when `cfg_even`=1, whatever the data. A mismatch sets `rx_perr`.
- R6: With `cfg_par_en`=0 no parity bit is expected, the stop bit directly follows the data, and `rx_perr` is never set.
- R7: `rx_ferr` is set when the stop-bit sample is low.
- R8: Only one stop bit is sampled. A start bit beginning right after a single stop bit is received as the next character.
- R9: When every data sample, the parity sample (if enabled) and the stop sample are all low, one character is reported with `rx_data`=0, `rx_brk`=1, `rx_ferr`=1 and `rx_perr`=0.
- R10: After a break, no further character is reported until the line has been sampled high, however long it stays low.
- R11: `rx_valid` is high for exactly one clock per character. `rx_data` and the flags hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_line | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_even | input | 1 | Even parity select / stick value select |
| cfg_stick | input | 1 | Stick parity mode |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error flag |
| rx_ferr | output | 1 | Framing error flag |
| rx_brk | output | 1 | Break detected flag |

## Verification
Break detection and framing-error detection fall on the same stop-bit sample. Both fire on a low stop bit, and a true break must also carry a zero parity check result. The bench provokes this by sending an all-zero frame whose stop bit is low, and by comparing it against a non-zero frame with a low stop bit. The behavioural model expects `rx_ferr` with `rx_brk` in the first case and `rx_ferr` alone in the second. The model also expects exactly one strobe while the line then stays low for several frame times.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    // Length code to data bit count: 0..3 -> 5..8
    function automatic logic [3:0] wlen_to_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              even_sel,
    input  logic              stick,
    output logic              exp_bit
);
    // Unused upper data bits are zero, so a full reduction is safe.
    always_comb begin
        if (stick) exp_bit = ~even_sel;
        else       exp_bit = even_sel ? (^data) : ~(^data);
    end
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_even,
    input  logic              cfg_stick,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk
);
    import uart_rx_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par_smp;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic line_s;
    logic exp_par;
    logic [IDX_W-1:0] last_idx;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .q_out (line_s)
    );

    uart_rx_parity #(.DATA_W(DATA_W)) u_par (
        .data     (r_q.shreg),
        .even_sel (cfg_even),
        .stick    (cfg_stick),
        .exp_bit  (exp_par)
    );

    assign last_idx = IDX_W'(wlen_to_bits(cfg_wlen) - 4'd1);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (tick16 && !line_s) begin
                    r_d.state = ST_START;
                    r_d.cnt   = '0;
                end
            end
            ST_START: begin
                if (tick16) begin
                    if (r_q.cnt == MID_CNT) begin
                        r_d.cnt = '0;
                        if (!line_s) begin
                            r_d.state   = ST_DATA;
                            r_d.idx     = '0;
                            r_d.shreg   = '0;
                            r_d.par_smp = 1'b0;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick16) begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt             = '0;
                        r_d.shreg[r_q.idx]  = line_s;
                        if (r_q.idx == last_idx)
                            r_d.state = cfg_par_en ? ST_PAR : ST_STOP;
                        else
                            r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick16) begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt     = '0;
                        r_d.par_smp = line_s;
                        r_d.state   = ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick16) begin
                    if (r_q.cnt == LAST_CNT) begin
                        r_d.cnt   = '0;
                        r_d.valid = 1'b1;
                        r_d.data  = r_q.shreg;
                        r_d.ferr  = !line_s;
                        r_d.brk   = (r_q.shreg == '0) && !line_s &&
                                    (!cfg_par_en || !r_q.par_smp);
                        r_d.perr  = cfg_par_en && !r_d.brk &&
                                    (r_q.par_smp != exp_par);
                        r_d.state = r_d.brk ? ST_BRKWAIT : ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_BRKWAIT: begin
                if (tick16 && line_s) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_valid = r_q.valid;
    assign rx_data  = r_q.data;
    assign rx_perr  = r_q.perr;
    assign rx_ferr  = r_q.ferr;
    assign rx_brk   = r_q.brk;

    // R11: strobe lasts one clock only
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: outputs hold between strobes
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));

    // R9: break reports a zero character with framing set and parity clear
    a_r9_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == '0 && rx_ferr && !rx_perr));

    // R6: no parity error while parity is off
    a_r6_no_perr_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_perr);

    // R3: five-bit characters keep upper bits clear
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_wlen == 2'b00) |-> ((rx_data >> 5) == '0));

    // R10: no new character while waiting for the line to rise after a break
    a_r10_brk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BRKWAIT && !line_s) |=> !rx_valid);

endmodule

// File: tb/uart_rx_deframer_tb.sv
module uart_rx_deframer_tb;
    localparam int BIT_CLKS = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_even = 1'b0;
    logic       cfg_stick = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       bk;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic [7:0] last_data = 8'h00;
    bit   check_hold = 0;

    always #2 clk = ~clk;

    uart_rx_deframer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .rx_line    (rx_line),
        .cfg_wlen   (cfg_wlen),
        .cfg_par_en (cfg_par_en),
        .cfg_even   (cfg_even),
        .cfg_stick  (cfg_stick),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_brk     (rx_brk)
    );

    always @(negedge clk) tick16 <= ~tick16;

    // Per-clock comparison against the expected-character queue
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            if (check_hold) begin
                n_checks++;
                if (rx_valid || rx_data !== last_data) begin
                    n_fail++;
                    $display("FAIL R11: valid=%0b data=%h expected valid=0 data=%h",
                             rx_valid, rx_data, last_data);
                end
                check_hold = 0;
            end
            if (rx_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2/R10: unexpected char data=%h p=%0b f=%0b b=%0b expected none",
                             rx_data, rx_perr, rx_ferr, rx_brk);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rx_data !== e.d || rx_perr !== e.pe ||
                        rx_ferr !== e.fe || rx_brk !== e.bk) begin
                        n_fail++;
                        $display("FAIL %s: got d=%h p=%0b f=%0b b=%0b expected d=%h p=%0b f=%0b b=%0b",
                                 e.tag, rx_data, rx_perr, rx_ferr, rx_brk,
                                 e.d, e.pe, e.fe, e.bk);
                    end
                end
                last_data  = rx_data;
                check_hold = 1;
            end
        end
    end

    task automatic drive(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    // Sends one frame and queues the character the requirements predict
    task automatic send_frame(input logic [7:0] d, input logic stop_lvl,
                              input logic bad_par, input string tag);
        int   nb;
        logic [7:0] dm;
        logic p;
        exp_t e;
        nb = 5 + int'(cfg_wlen);
        dm = d & 8'((1 << nb) - 1);
        if (cfg_stick) p = ~cfg_even;
        else           p = cfg_even ? (^dm) : ~(^dm);
        p = p ^ bad_par;
        e.d   = dm;
        e.fe  = ~stop_lvl;
        e.bk  = (dm == 8'h00) && !stop_lvl && (!cfg_par_en || !p);
        e.pe  = cfg_par_en && !e.bk && bad_par;
        e.tag = tag;
        exp_q.push_back(e);
        drive(1'b0, BIT_CLKS);
        for (int i = 0; i < nb; i++) drive(dm[i], BIT_CLKS);
        if (cfg_par_en) drive(p, BIT_CLKS);
        if (stop_lvl) drive(1'b1, BIT_CLKS);
        else begin
            drive(1'b0, 24);
            drive(1'b1, BIT_CLKS);
        end
    endtask

    task automatic expect_drained(input string tag);
        repeat (BIT_CLKS * 2) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d characters missing, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        n_checks++;
        if (rx_valid !== 1'b0 || rx_data !== 8'h00 || rx_perr !== 1'b0 ||
            rx_ferr !== 1'b0 || rx_brk !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: v=%0b d=%h p=%0b f=%0b b=%0b expected all zero",
                     rx_valid, rx_data, rx_perr, rx_ferr, rx_brk);
        end
        rst_n = 1'b1;
        drive(1'b1, BIT_CLKS * 2);

        // R3: each length code, no parity
        for (int w = 0; w < 4; w++) begin
            cfg_wlen = 2'(w);
            send_frame(8'hA5, 1'b1, 1'b0, "R3");
            send_frame(8'h5A, 1'b1, 1'b0, "R3");
        end
        expect_drained("R3");

        // R4: odd and even parity, good and corrupted
        cfg_wlen = 2'b11; cfg_par_en = 1'b1; cfg_stick = 1'b0;
        for (int ev = 0; ev < 2; ev++) begin
            cfg_even = 1'(ev);
            send_frame(8'h37, 1'b1, 1'b0, "R4");
            send_frame(8'h37, 1'b1, 1'b1, "R4");
            send_frame(8'hF0, 1'b1, 1'b1, "R4");
        end
        expect_drained("R4");

        // R5: stick parity both ways
        cfg_stick = 1'b1; cfg_wlen = 2'b10;
        for (int ev = 0; ev < 2; ev++) begin
            cfg_even = 1'(ev);
            send_frame(8'h11, 1'b1, 1'b0, "R5");
            send_frame(8'h13, 1'b1, 1'b1, "R5");
        end
        expect_drained("R5");

        // R6: parity off, no parity bit
        cfg_stick = 1'b0; cfg_par_en = 1'b0; cfg_wlen = 2'b11;
        send_frame(8'hC3, 1'b1, 1'b0, "R6");
        send_frame(8'h01, 1'b1, 1'b0, "R6");
        expect_drained("R6");

        // R7: low stop bit on a non-zero character
        send_frame(8'h81, 1'b0, 1'b0, "R7");
        drive(1'b1, BIT_CLKS * 2);
        expect_drained("R7");

        // R8: back-to-back frames with one stop bit
        send_frame(8'h55, 1'b1, 1'b0, "R8");
        send_frame(8'hAA, 1'b1, 1'b0, "R8");
        send_frame(8'h0F, 1'b1, 1'b0, "R8");
        expect_drained("R8");

        // R2: short low pulse then a real frame
        drive(1'b0, 8);
        drive(1'b1, BIT_CLKS * 2);
        expect_drained("R2");
        send_frame(8'h3C, 1'b1, 1'b0, "R2");
        expect_drained("R2");

        // R9 and R10: break with parity on, line held low for several frames
        cfg_par_en = 1'b1; cfg_even = 1'b1;
        begin
            exp_t e;
            e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1; e.bk = 1'b1; e.tag = "R9";
            exp_q.push_back(e);
        end
        drive(1'b0, BIT_CLKS * 40);
        drive(1'b1, BIT_CLKS * 2);
        expect_drained("R10");
        send_frame(8'h66, 1'b1, 1'b0, "R10");
        expect_drained("R10");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule